// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This controller connects a host-side request port to a 64-word by 16-bit serial EEPROM that uses chip select, serial clock, serial data-in and serial data-out lines. The host presents one of four commands on a valid/ready handshake: read a word, write a word, enable writes, or disable writes. The block then serialises the frame one bit at a time. A frame is a leading zero, a start bit, a two-bit opcode, the word address and, for reads and writes, sixteen data bits. Every field travels most significant bit first.

Each serial bit takes three equal phases: the data line is set with the clock low, the clock is raised, and the clock is dropped. The phase length is a parameter, so the EEPROM's minimum clock high and low times can be met from any system clock. After a write, chip select is dropped for one phase and then raised again. The controller then samples the EEPROM's ready/busy level on data-out once per phase until it reads 1. If it has made a parameterised number of polls without seeing 1, it gives up and flags an error. Completion is signalled by a one-cycle pulse, which carries the read word or the error flag with it.

A write takes effect only inside an enable/disable bracket. The host is responsible for issuing the write-enable command before a write and the write-disable command after it.

Top module: `serial_eeprom_ctrl`

## Requirements
- R1: While reset is low and after its release, `ee_cs_o`, `ee_sk_o`, `ee_di_o`, `done_o` and `err_o` are 0, `req_ready_o` is 1 and `rdata_o` is 0.
- R2: Each command raises chip select and shifts exactly one 0 bit, then a 1 start bit, then a 2-bit opcode, then the AW-bit address, all MSB first. The opcodes are: read 10, write 01, write-enable and write-disable 00.
- R3: Host command code `req_op_i` = 0 reads. The 16 bits sampled from `ee_do_i` while `ee_sk_o` is high after the address appear MSB first on `rdata_o` in the cycle `done_o` pulses. `rdata_o` holds that value until the next read completes.
- R4: Host command code 1 writes. The 16 bits of `req_wdata_i` are shifted out on `ee_di_o` MSB first after the address.
- R5: Host code 2 sends the write-enable command, which is opcode 00 with address top bits 11 and the remaining bits 0. Host code 3 sends the write-disable command, which is opcode 00 with an all-zero address. A write issued after write-disable leaves the stored word unchanged.
- R6: Each bit takes three phases of CLK_DIV clock cycles: data set with the clock low, clock high, clock low. `ee_sk_o` is high only while `ee_cs_o` is high, and `ee_di_o` does not change while `ee_sk_o` is high.
- R7: After the data bits of a write, `ee_cs_o` goes low for one phase and is then raised again. `ee_do_i` is sampled once per phase until it reads 1. The command then completes with `err_o` = 0.
- R8: If POLL_MAX polls see `ee_do_i` at 0, the write completes with `err_o` = 1 in the same cycle as `done_o`.
- R9: `req_ready_o` is low from the cycle after a request is accepted until the cycle its `done_o` pulses. Requests presented while it is low are ignored.
- R10: `done_o` is a single-cycle pulse, once per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Command request valid |
| req_ready_o | output | 1 | Controller idle, request accepted when valid |
| req_op_i | input | 2 | Command: 0 read, 1 write, 2 write-enable, 3 write-disable |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Word to write |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Write ready poll timed out (valid with done_o) |
| rdata_o | output | DW | Last word read |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to EEPROM |
| ee_do_i | input | 1 | Serial data / ready-busy from EEPROM |

## Verification
The bench builds the controller with CLK_DIV = 2 and POLL_MAX = 8, keeping the defaults of a 6-bit address and a 16-bit word. The short phase keeps each 26-bit frame within a few hundred cycles. With only eight polls allowed, both exits of the ready poll can be reached in one run: a behavioural EEPROM that is busy for a few cycles tests the normal exit, and one held busy tests the timeout. The same model decodes the leading zero, start bit, opcode and address of every frame, so the bench can check the command encodings and the write-protect bracket at the pins.

// File: rtl/se_pkg.sv
package se_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_WEN   = 2'd2,
    CMD_WDS   = 2'd3
  } se_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_POLL
  } se_state_e;

  typedef enum logic [1:0] {
    PH_SET,
    PH_HIGH,
    PH_LOW
  } se_phase_e;
endpackage

// File: rtl/se_phase_div.sv
module se_phase_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = !clr_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  // R6: phase counter never passes its terminal count
  a_r6_div_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DIV - 1));
endmodule

// File: rtl/se_poll_ctr.sv
module se_poll_ctr #(
  parameter int unsigned POLL_MAX = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(POLL_MAX + 1);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(POLL_MAX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // R8: failed polls never reach the limit without the timeout exit
  a_r8_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(POLL_MAX));
endmodule

// File: rtl/serial_eeprom_ctrl.sv
module serial_eeprom_ctrl
  import se_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 4,
  parameter int unsigned POLL_MAX = 10000,
  parameter int unsigned AW       = 6,
  parameter int unsigned DW       = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic          ee_cs_o,
  output logic          ee_sk_o,
  output logic          ee_di_o,
  input  logic          ee_do_i
);
  localparam int unsigned HDR_W = 4 + AW;
  localparam int unsigned FRM_W = HDR_W + DW;
  localparam int unsigned BW    = $clog2(FRM_W);

  se_state_e     state_q;
  se_phase_e     phase_q;
  logic [BW-1:0] bit_q;
  logic [FRM_W-1:0] sr_q;
  logic [DW-1:0] rd_sr_q;
  logic          is_rd_q, is_wr_q, long_q;
  logic          tick, poll_last;
  logic          cs_q, sk_q, di_q, done_q, err_q;
  logic [DW-1:0] rdata_q;

  logic [1:0]       opc;
  logic [AW-1:0]    adr;
  logic [FRM_W-1:0] frame;
  logic [BW-1:0]    last_bit;
  se_cmd_e          cmd;

  assign cmd = se_cmd_e'(req_op_i);

  always_comb begin
    opc = 2'b00;
    adr = '0;
    unique case (cmd)
      CMD_READ:  begin opc = 2'b10; adr = req_addr_i; end
      CMD_WRITE: begin opc = 2'b01; adr = req_addr_i; end
      CMD_WEN:   begin opc = 2'b00; adr = {2'b11, {(AW-2){1'b0}}}; end
      default:   begin opc = 2'b00; adr = '0; end
    endcase
    frame = {1'b0, 1'b1, opc, adr, req_wdata_i};
  end

  assign last_bit = long_q ? BW'(FRM_W - 1) : BW'(HDR_W - 1);

  se_phase_div #(.DIV(CLK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE),
    .tick_o (tick)
  );

  se_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != ST_POLL),
    .inc_i  ((state_q == ST_POLL) && tick && !ee_do_i && !poll_last),
    .last_o (poll_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_SET;
      bit_q   <= '0;
      sr_q    <= '0;
      rd_sr_q <= '0;
      is_rd_q <= 1'b0;
      is_wr_q <= 1'b0;
      long_q  <= 1'b0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          sr_q    <= frame;
          is_rd_q <= (cmd == CMD_READ);
          is_wr_q <= (cmd == CMD_WRITE);
          long_q  <= (cmd == CMD_READ) || (cmd == CMD_WRITE);
          cs_q    <= 1'b1;
          sk_q    <= 1'b0;
          di_q    <= frame[FRM_W-1];
          phase_q <= PH_SET;
          bit_q   <= '0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          unique case (phase_q)
            PH_SET: begin
              sk_q    <= 1'b1;
              phase_q <= PH_HIGH;
            end
            PH_HIGH: begin
              sk_q <= 1'b0;
              if (is_rd_q && bit_q >= BW'(HDR_W))
                rd_sr_q <= {rd_sr_q[DW-2:0], ee_do_i};
              phase_q <= PH_LOW;
            end
            default: begin
              if (bit_q == last_bit) begin
                cs_q    <= 1'b0;
                di_q    <= 1'b0;
                state_q <= ST_GAP;
              end else begin
                bit_q   <= bit_q + 1'b1;
                sr_q    <= sr_q << 1;
                di_q    <= sr_q[FRM_W-2];
                phase_q <= PH_SET;
              end
            end
          endcase
        end
        ST_GAP: if (tick) begin
          if (is_wr_q) begin
            cs_q    <= 1'b1;
            state_q <= ST_POLL;
          end else begin
            done_q  <= 1'b1;
            if (is_rd_q) rdata_q <= rd_sr_q;
            state_q <= ST_IDLE;
          end
        end
        default: if (tick && (ee_do_i || poll_last)) begin
          cs_q    <= 1'b0;
          done_q  <= 1'b1;
          err_q   <= !ee_do_i;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign rdata_o     = rdata_q;
  assign ee_cs_o     = cs_q;
  assign ee_sk_o     = sk_q;
  assign ee_di_o     = di_q;

  a_r6_sk_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> ee_cs_o);
  a_r6_sk_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(ee_sk_o));
  a_r6_di_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> $stable(ee_di_o));
  a_r8_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  a_r9_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_poll_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL) |-> ee_cs_o);
endmodule

// File: tb/serial_eeprom_ctrl_test.sv
`timescale 1ns/1ps
module serial_eeprom_ctrl_test;
  localparam int unsigned CLK_DIV  = 2;
  localparam int unsigned POLL_MAX = 8;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 16;
  localparam int unsigned BUSY = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic done, err;
  logic [DW-1:0] rdata;
  logic cs, sk, di, dout;

  always #10 clk = ~clk;

  serial_eeprom_ctrl #(.CLK_DIV(CLK_DIV), .POLL_MAX(POLL_MAX), .AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .done_o(done), .err_o(err), .rdata_o(rdata),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(dout)
  );

  // behavioural EEPROM
  logic [15:0] mem [64];
  logic wen = 1'b0, started = 1'b0, stuck = 1'b0;
  logic poll_mode = 1'b0, rd_do = 1'b0;
  int   busy_cnt = 0;
  int   zeros = 0, hcnt = 0, dcnt = 0, frames = 0;
  logic [7:0]  hdr = '0;
  logic [15:0] wsr = '0;
  logic prev_cs = 1'b0, prev_sk = 1'b0;

  assign dout = poll_mode ? (busy_cnt == 0 && !stuck) : rd_do;

  initial for (int i = 0; i < 64; i++) mem[i] = 16'h0F00 + 16'(i);

  always @(posedge clk) begin
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (cs && !prev_cs && !poll_mode) begin
      started = 1'b0; zeros = 0; hcnt = 0; dcnt = 0; hdr = '0; wsr = '0;
      frames = frames + 1;
    end
    if (cs && sk && !prev_sk) begin
      if (!started) begin
        if (di) started = 1'b1; else zeros = zeros + 1;
      end else if (hcnt < 8) begin
        hdr = {hdr[6:0], di}; hcnt = hcnt + 1;
      end else begin
        if (hdr[7:6] == 2'b10) rd_do <= mem[hdr[5:0]][15-dcnt];
        else wsr = {wsr[14:0], di};
        dcnt = dcnt + 1;
      end
    end
    if (!cs && prev_cs) begin
      rd_do <= 1'b0;
      if (poll_mode) poll_mode <= 1'b0;
      else if (hcnt == 8 && hdr[7:6] == 2'b01 && dcnt == 16) begin
        poll_mode <= 1'b1;
        if (wen) begin mem[hdr[5:0]] = wsr; busy_cnt <= BUSY; end
      end else if (hcnt == 8 && hdr[7:6] == 2'b00) begin
        if (hdr[5:4] == 2'b11) wen = 1'b1;
        else if (hdr[5:4] == 2'b00) wen = 1'b0;
      end
    end
    prev_cs <= cs;
    prev_sk <= sk;
  end

  // pin-level monitors (R6, R10)
  int viol_sk = 0, viol_di = 0, viol_done = 0;
  logic m_sk = 1'b0, m_di = 1'b0, m_done = 1'b0;
  always @(negedge clk) begin
    if (sk && !cs) viol_sk++;
    if (sk && m_sk && di != m_di) viol_di++;
    if (done && m_done) viol_done++;
    m_sk = sk; m_di = di; m_done = done;
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                         output logic er);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    rd = rdata; er = err;
  endtask

  function automatic logic [7:0] exp_hdr(input logic [1:0] op, input logic [5:0] a);
    case (op)
      2'd0: exp_hdr = {2'b10, a};
      2'd1: exp_hdr = {2'b01, a};
      2'd2: exp_hdr = 8'b00_110000;
      default: exp_hdr = 8'b00_000000;
    endcase
  endfunction

  // {op, addr, wdata, expected read, check read, expected err}
  localparam int NV = 11;
  localparam logic [41:0] VEC [NV] = '{
    {2'd2, 6'd0,  16'h0000, 16'h0000, 1'b0, 1'b0},
    {2'd1, 6'd5,  16'hA5C3, 16'h0000, 1'b0, 1'b0},
    {2'd0, 6'd5,  16'h0000, 16'hA5C3, 1'b1, 1'b0},
    {2'd1, 6'd63, 16'h8001, 16'h0000, 1'b0, 1'b0},
    {2'd0, 6'd63, 16'h0000, 16'h8001, 1'b1, 1'b0},
    {2'd1, 6'd0,  16'hFFFF, 16'h0000, 1'b0, 1'b0},
    {2'd0, 6'd0,  16'h0000, 16'hFFFF, 1'b1, 1'b0},
    {2'd3, 6'd0,  16'h0000, 16'h0000, 1'b0, 1'b0},
    {2'd1, 6'd5,  16'h1234, 16'h0000, 1'b0, 1'b0},
    {2'd0, 6'd5,  16'h0000, 16'hA5C3, 1'b1, 1'b0},
    {2'd0, 6'd1,  16'h0000, 16'h0F01, 1'b1, 1'b0}
  };

  initial begin
    logic [DW-1:0] rd, last_rd;
    logic er;
    int f0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({cs, sk, di, done, err} == 5'b0, "R1 pins in reset", {cs, sk, di, done, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rdata == '0 && !cs, "R1 rdata/cs after reset", rdata, 0);

    last_rd = '0;
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [5:0] a; logic [15:0] wd, ex; logic cr, ee;
      {op, a, wd, ex, cr, ee} = VEC[i];
      run_cmd(op, a, wd, rd, er);
      chk(zeros == 1, "R2 one leading zero", zeros, 1);
      chk(hdr == exp_hdr(op, a), (op >= 2) ? "R5 enable/disable opcode" : "R2 opcode/address",
          hdr, exp_hdr(op, a));
      chk(er == ee, (op == 1) ? "R7 write completes without error" : "R8 err only on timeout", er, ee);
      if (cr) begin
        chk(rd == ex, (i == 9) ? "R5 write after disable ignored" : "R3/R4 read back word", rd, ex);
        last_rd = rd;
      end else begin
        chk(rd == last_rd, "R3 rdata held", rd, last_rd);
      end
    end

    // R9: requests while busy are ignored
    f0 = frames;
    @(negedge clk);
    req_op = 2'd0; req_addr = 6'd2; req_valid = 1'b1;
    @(negedge clk);
    req_op = 2'd1; req_wdata = 16'hDEAD;
    repeat (20) begin
      @(negedge clk);
      chk(!req_ready, "R9 ready low while busy", req_ready, 0);
    end
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(rdata == 16'h0F02, "R9 read during held request", rdata, 16'h0F02);
    @(negedge clk);
    chk(frames == f0 + 1, "R9 one frame only", frames, f0 + 1);

    // R8: timeout on stuck busy
    run_cmd(2'd2, 6'd0, 16'h0, rd, er);
    stuck = 1'b1;
    run_cmd(2'd1, 6'd9, 16'h5555, rd, er);
    chk(er == 1'b1, "R8 poll timeout raises err", er, 1);
    stuck = 1'b0;
    run_cmd(2'd1, 6'd10, 16'h3C3C, rd, er);
    chk(er == 1'b0, "R7 poll ok after recovery", er, 0);
    run_cmd(2'd0, 6'd10, 16'h0, rd, er);
    chk(rd == 16'h3C3C, "R4 write MSB first", rd, 16'h3C3C);

    @(negedge clk);
    chk(viol_sk == 0, "R6 sk only with cs", viol_sk, 0);
    chk(viol_di == 0, "R6 di stable while sk high", viol_di, 0);
    chk(viol_done == 0, "R10 done single cycle", viol_done, 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule